// File: doc/BRIEF.md
# Clocked Control Core for a Bytewide Nonvolatile SRAM-Style Memory

This block models the control side of a byte-wide nonvolatile memory that is driven like an asynchronous SRAM. A fast system clock samples the strobes and the address. From these samples the block works out when an access starts and latches the address. It sorts each bus cycle into a read or a write, serves column accesses within an open row, and inserts a precharge interval between rows. It also produces the enable for a tri-state data bus. Storage is an inferred RAM inside the block.

The address is split into a row part (upper bits) and a column part (the lowest `COL_W` bits). With `ROW_W = 14` and `COL_W = 3` the block covers 128K bytes. The default is a smaller row count so that the default elaboration stays small. The access latency, the page latency and the precharge length are parameters counted in clock cycles. The strobes are active-low chip enable, active-high chip enable, active-low write enable and active-low output enable. Each of them, the address and the write data pass through a two-flop synchronizer, and the block detects edges on the synchronized copies.

Top module: `pfram_port`

## Requirements
- R1: The block is selected when `ce1_n` is 0 and `ce2` is 1. A new access starts only when the selection turns on, either through `ce1_n` falling while `ce2` is high or through `ce2` rising while `ce1_n` is low. When `we_n` is high and `oe_n` is low, `dq_oe` rises exactly `T_ACC+3` clock edges after the enabling pin changes, and not before.
- R2: The full address is latched when the access starts. Bits `[ROW_W+COL_W-1:COL_W]` give the row and bits `[COL_W-1:0]` give the byte within the row. A read returns the byte last written to that address.
- R3: If `we_n` is low when the access starts, the cycle is a write, and `dq_oe` stays 0 for as long as `we_n` is low, whatever the level of `oe_n`.
- R4: If `we_n` falls during an open access, the cycle turns into a write. `dq_oe` drops 2 edges after `we_n` falls. After `we_n` rises, the written byte appears on the bus `T_PAGE+3` edges later.
- R5: Write data is taken at whichever comes first of `we_n` rising and the selection turning off (`ce1_n` rising or `ce2` falling). Data that changes, or a `we_n` rise that comes, after that point has no effect.
- R6: `dq_oe` is 1 only while `oe_n` is low and the access latency has elapsed. Raising `oe_n` clears `dq_oe` 2 edges later, and lowering it again restores the bus 2 edges later.
- R7: While the block is selected and `we_n` is high, a change of the column bits alone opens a page access. The bus goes undriven and shows the new byte `T_PAGE+3` edges after the change.
- R8: Each falling edge of `we_n` latches a new column, so one selection can write every byte of the open row in turn.
- R9: A change of the row bits while the block is selected and `we_n` is high starts a precharge of `T_PC` cycles. The new row then opens without any further edge, and data is driven `T_PC+T_ACC+3` edges after the change.
- R10: Turning the selection off starts a precharge of `T_PC` cycles. A reselection that arrives during the precharge is held until the precharge ends, and the access then starts by itself.
- R11: One `we_n` pulse writes exactly one byte, to the column latched at its falling edge. A column change during the pulse does not write the new column.
- R12: While `rst_n` is low, and after reset, the block is idle and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every bus pin |
| rst_n | input | 1 | Synchronous active-low reset |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ROW_W+COL_W | Byte address: row in the upper bits, column in the low `COL_W` bits |
| dq_in | input | DATA_W | Write data seen on the bus |
| dq_out | output | DATA_W | Read data offered to the bus |
| dq_oe | output | 1 | Bus driver enable, 1 = drive `dq_out` |

## Verification
Two events can land in the same cycle: the end of a pending write and the start of a precharge. This happens when the selection drops while `we_n` is still low. The bench provokes it with a write that is set up by the chip enable. It releases the enable with `we_n` held low, then changes the data and only afterwards raises `we_n`. A later read judges the result, which must return the byte present at deselection. The bench also reselects during a running precharge and checks that the resulting access is delayed by exactly the remaining precharge.

// File: rtl/pfram_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers of the clocked memory control core.
// Assumes nothing beyond standard SystemVerilog elaboration.
package pfram_pkg;

    // Phase of the current access.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRECH  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_OPEN   = 2'd3
    } acc_state_t;

    // Bit positions inside the synchronized strobe vector.
    localparam int STB_CE1N = 0;
    localparam int STB_CE2  = 1;
    localparam int STB_WEN  = 2;
    localparam int STB_OEN  = 3;
    localparam int STB_W    = 4;

    // Largest of three counts, used to size the latency counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pfram_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled independently; multi-bit values must be
// held stable for at least two clocks around the strobe that uses them.
module pfram_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Shift the raw inputs through two flops, resetting to the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/pfram_array.sv
`timescale 1ns/1ps
// Module: inferred single-port-write, registered-read byte storage.
// Assumes the controller keeps the read address steady for at least one
// clock before it enables the bus. Contents have no reset (nonvolatile model).
module pfram_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit one byte per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the byte at the open address every cycle.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/pfram_ctrl.sv
`timescale 1ns/1ps
// Module: access sequencer. Detects selection edges, latches row and column,
// times access, page and precharge intervals, arms and commits writes, and
// computes the bus driver enable.
// Assumes all inputs arrive already synchronized; T_ACC, T_PAGE, T_PC >= 1.
module pfram_ctrl
    import pfram_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 4,
    parameter int T_PAGE = 2,
    parameter int T_PC   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STB_W-1:0]       stb_s,
    input  logic [ROW_W+COL_W-1:0] addr_s,
    input  logic [DATA_W-1:0]      data_s,
    output logic                   wr_en,
    output logic [ROW_W+COL_W-1:0] wr_addr,
    output logic [DATA_W-1:0]      wr_data,
    output logic [ROW_W+COL_W-1:0] rd_addr,
    output logic                   dq_oe
);

    localparam int AW    = ROW_W + COL_W;
    localparam int CNT_W = $clog2(max3(T_ACC, T_PAGE, T_PC) + 1);
    localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(T_ACC - 1);
    localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(T_PAGE - 1);
    localparam logic [CNT_W-1:0] PC_LOAD   = CNT_W'(T_PC - 1);

    acc_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             reopen_q, reopen_n;
    logic             armed_q, armed_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic [COL_W-1:0] col_q, col_n;
    logic [2:0]       stb_prev;

    logic sel_now, sel_prev, we_now, we_prev, oe_now;
    logic start_e, desel_e, we_rise, we_fall;
    logic [ROW_W-1:0] row_in;
    logic [COL_W-1:0] col_in;

    // Decode selection and write strobe levels and their edges.
    always_comb begin
        sel_now  = ~stb_s[STB_CE1N] & stb_s[STB_CE2];
        sel_prev = ~stb_prev[STB_CE1N] & stb_prev[STB_CE2];
        we_now   = stb_s[STB_WEN];
        we_prev  = stb_prev[STB_WEN];
        oe_now   = stb_s[STB_OEN];
        start_e  = sel_now & ~sel_prev;
        desel_e  = ~sel_now & sel_prev;
        we_rise  = we_now & ~we_prev;
        we_fall  = ~we_now & we_prev;
        row_in   = addr_s[AW-1:COL_W];
        col_in   = addr_s[COL_W-1:0];
    end

    // Next-state logic for the access sequencer.
    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        reopen_n = reopen_q;
        armed_n  = armed_q;
        row_n    = row_q;
        col_n    = col_q;
        case (state_q)
            ST_IDLE: begin
                if (start_e) begin
                    state_n = ST_ACCESS;
                    cnt_n   = ACC_LOAD;
                    row_n   = row_in;
                    col_n   = col_in;
                    armed_n = ~we_now;
                end
            end
            ST_PRECH: begin
                if (start_e) reopen_n = 1'b1;
                if (cnt_q == '0) begin
                    reopen_n = 1'b0;
                    if ((reopen_q | start_e) & sel_now) begin
                        state_n = ST_ACCESS;
                        cnt_n   = ACC_LOAD;
                        row_n   = row_in;
                        col_n   = col_in;
                        armed_n = ~we_now;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: begin
                if (state_q == ST_ACCESS) begin
                    if (cnt_q == '0) state_n = ST_OPEN;
                    else             cnt_n   = cnt_q - 1'b1;
                end
                if (desel_e) begin
                    state_n  = ST_PRECH;
                    cnt_n    = PC_LOAD;
                    reopen_n = 1'b0;
                    armed_n  = 1'b0;
                end else if (armed_q & we_rise) begin
                    armed_n = 1'b0;
                    state_n = ST_ACCESS;
                    cnt_n   = PAGE_LOAD;
                end else if (we_fall) begin
                    armed_n = 1'b1;
                    col_n   = col_in;
                end else if (we_now & ~armed_q & (row_in != row_q)) begin
                    state_n  = ST_PRECH;
                    cnt_n    = PC_LOAD;
                    reopen_n = 1'b1;
                end else if (we_now & ~armed_q & (col_in != col_q)) begin
                    col_n = col_in;
                    if (state_q == ST_OPEN) begin
                        state_n = ST_ACCESS;
                        cnt_n   = PAGE_LOAD;
                    end
                end
            end
        endcase
    end

    // Register sequencer state and the previous strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            reopen_q <= 1'b0;
            armed_q  <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            stb_prev <= 3'b101;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            reopen_q <= reopen_n;
            armed_q  <= armed_n;
            row_q    <= row_n;
            col_q    <= col_n;
            stb_prev <= stb_s[2:0];
        end
    end

    // Write strobe, addressing and bus enable.
    always_comb begin
        wr_en   = armed_q & (we_rise | desel_e);
        wr_addr = {row_q, col_q};
        wr_data = data_s;
        rd_addr = {row_q, col_q};
        dq_oe   = (state_q == ST_OPEN) & sel_now & we_now & ~oe_now & ~armed_q;
    end

    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS && $past(state_q) == ST_IDLE) |-> $past(start_e))
        else $error("access opened without a selection edge"); // R1
    AST_ARMED_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> !we_prev)
        else $error("write armed while write strobe was high"); // R3
    AST_WRITE_INSIDE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == ST_ACCESS || state_q == ST_OPEN))
        else $error("write outside an access"); // R5
    AST_ROW_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) == ST_OPEN) |-> $stable(row_q))
        else $error("row moved while open"); // R9
    AST_PRECH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PRECH && $past(state_q) == ST_PRECH) |-> $past(cnt_q) == '0)
        else $error("precharge cut short"); // R10
    AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en)
        else $error("two writes in a row"); // R11

endmodule

// File: rtl/pfram_port.sv
`timescale 1ns/1ps
// Module: top of the clocked control core. Synchronizes the bus pins,
// sequences accesses and holds the storage array.
// Assumes pins are held stable for two or more clocks around each strobe edge.
module pfram_port
    import pfram_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 4,
    parameter int T_PAGE = 2,
    parameter int T_PC   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce1_n,
    input  logic                   ce2,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [DATA_W-1:0]      dq_in,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe
);

    localparam int AW = ROW_W + COL_W;
    localparam logic [STB_W-1:0] STB_IDLE = 4'b1101;

    logic [STB_W-1:0]  stb_raw, stb_s;
    logic [AW-1:0]     addr_s, wr_addr, rd_addr;
    logic [DATA_W-1:0] data_s, wr_data;
    logic              wr_en;

    // Gather the strobe pins into one vector.
    always_comb begin
        stb_raw = '0;
        stb_raw[STB_CE1N] = ce1_n;
        stb_raw[STB_CE2]  = ce2;
        stb_raw[STB_WEN]  = we_n;
        stb_raw[STB_OEN]  = oe_n;
    end

    pfram_sync #(.W(STB_W), .RST_VAL(STB_IDLE)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s));

    pfram_sync #(.W(AW), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));

    pfram_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(dq_in), .q(data_s));

    pfram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PC(T_PC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .addr_s(addr_s),
        .data_s(data_s), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .dq_oe(dq_oe));

    pfram_array #(.AW(AW), .DW(DATA_W)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(dq_out));

endmodule

// File: tb/tb_pfram_port.sv
`timescale 1ns/1ps
module tb_pfram_port;

    localparam int ROW_W = 8, COL_W = 3, DW = 8;
    localparam int T_ACC = 4, T_PAGE = 2, T_PC = 3;
    localparam int L_ACC  = T_ACC + 3;
    localparam int L_PAGE = T_PAGE + 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W+COL_W-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        bit         exp_oe;
        bit         chk_d;
        logic [7:0] exp_d;
    } item_t;
    item_t sb_q[$];
    event smp_ev;
    logic [7:0] row5 [8];

    always #2.5 clk = ~clk;

    pfram_port #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
                 .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PC(T_PC)) dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

    function automatic logic [ROW_W+COL_W-1:0] mk(input int r, input int c);
        return {ROW_W'(r), COL_W'(c)};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push an expected bus state and hand it to the monitor.
    task automatic expect_bus(input string req, input bit oe, input bit chk,
                              input logic [7:0] d);
        item_t it;
        it.req = req; it.exp_oe = oe; it.chk_d = chk; it.exp_d = d;
        sb_q.push_back(it);
        -> smp_ev;
    endtask

    // Monitor: pop expected items and compare with the bus outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (dq_oe !== it.exp_oe || (it.chk_d && dq_out !== it.exp_d)) begin
                    n_fail++;
                    $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
                             it.req, dq_oe, dq_out, it.exp_oe, it.exp_d);
                end
            end
        end
    end

    initial begin
        #(150_000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R12: reset holds the bus undriven
        cyc(3);
        expect_bus("R12 during reset", 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        cyc(4);
        expect_bus("R12 after reset", 1'b0, 1'b0, 8'h00);

        // R3 / R5: enable-started write, ended by deselect, late data ignored
        addr = mk(5, 2); dq_in = 8'h3C; we_n = 1'b0; oe_n = 1'b0;
        cyc(2);
        ce1_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            expect_bus("R3 bus quiet while we_n low", 1'b0, 1'b0, 8'h00);
        end
        ce1_n = 1'b1;
        cyc(3);
        dq_in = 8'h99;
        cyc(3);
        we_n = 1'b1;
        cyc(T_PC + 6);

        // R5 via ce2: enable-started write at row 9 col 1 ended by ce2 falling
        ce2 = 1'b0; cyc(2);
        ce1_n = 1'b0; we_n = 1'b0; addr = mk(9, 1); dq_in = 8'h91;
        cyc(3);
        ce2 = 1'b1;
        cyc(8);
        expect_bus("R3 quiet with oe_n low", 1'b0, 1'b0, 8'h00);
        ce2 = 1'b0;
        cyc(3);
        dq_in = 8'h00;
        cyc(2);
        we_n = 1'b1;
        cyc(2);
        ce1_n = 1'b1; cyc(2); ce2 = 1'b1;
        cyc(T_PC + 6);

        // R1 / R2 / R6: read started by ce1_n with oe_n low early
        addr = mk(5, 2);
        cyc(2);
        ce1_n = 1'b0;
        cyc(L_ACC - 1);
        expect_bus("R1 R6 not yet driven", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_bus("R1 R2 R5 first byte kept", 1'b1, 1'b1, 8'h3C);

        // R6: output enable gating
        oe_n = 1'b1;
        cyc(1);
        expect_bus("R6 still driven one edge", 1'b1, 1'b1, 8'h3C);
        cyc(1);
        expect_bus("R6 released", 1'b0, 1'b0, 8'h00);
        oe_n = 1'b0;
        cyc(2);
        expect_bus("R6 restored", 1'b1, 1'b1, 8'h3C);

        // R4: write strobe falls during a read
        we_n = 1'b0;
        cyc(1);
        expect_bus("R4 before sync", 1'b1, 1'b1, 8'h3C);
        cyc(1);
        expect_bus("R4 bus released", 1'b0, 1'b0, 8'h00);
        dq_in = 8'hA7;
        cyc(3);
        we_n = 1'b1;
        cyc(L_PAGE - 1);
        expect_bus("R4 latency after write", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_bus("R4 written byte", 1'b1, 1'b1, 8'hA7);

        // R8: page writes across the row, R11: column change inside a pulse
        for (int c = 0; c < 8; c++) begin
            if (c != 6) begin
                row5[c] = 8'h40 + 8'(c);
                addr = mk(5, c); dq_in = row5[c]; we_n = 1'b0;
                cyc(3);
                we_n = 1'b1;
                cyc(4);
            end
        end
        addr = mk(5, 6); dq_in = 8'h46; we_n = 1'b0;
        cyc(3);
        addr = mk(5, 7); dq_in = 8'hEE;
        cyc(3);
        we_n = 1'b1;
        row5[6] = 8'hEE;
        cyc(8);

        // R7 / R8 / R11: page reads of the whole row
        begin
            int order [8] = '{3, 0, 6, 1, 7, 2, 5, 4};
            for (int k = 0; k < 8; k++) begin
                addr = mk(5, order[k]);
                cyc(L_PAGE - 1);
                expect_bus("R7 page latency", 1'b0, 1'b0, 8'h00);
                cyc(1);
                expect_bus((order[k] == 7) ? "R11 other column untouched" :
                           "R7 R8 page byte", 1'b1, 1'b1, row5[order[k]]);
            end
        end

        // R9: row change while selected
        addr = mk(9, 1);
        cyc(T_PC + L_ACC - 1);
        expect_bus("R9 precharge then access", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_bus("R9 R5 new row byte", 1'b1, 1'b1, 8'h91);

        // R10: reselect during precharge is held off
        ce1_n = 1'b1;
        cyc(1);
        addr = mk(5, 2); ce1_n = 1'b0;
        cyc(T_PC + L_ACC - 2);
        expect_bus("R10 held off", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_bus("R10 access after precharge", 1'b1, 1'b1, 8'h42);

        // R1: access started by ce2 rising with ce1_n low
        ce2 = 1'b0;
        cyc(T_PC + 6);
        expect_bus("R10 idle after deselect", 1'b0, 1'b0, 8'h00);
        addr = mk(9, 1);
        cyc(2);
        ce2 = 1'b1;
        cyc(L_ACC - 1);
        expect_bus("R1 ce2 start not yet", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_bus("R1 ce2 start data", 1'b1, 1'b1, 8'h91);

        cyc(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule